// File: doc/BRIEF.md
# Serial byte engine with acknowledge handling

This block moves bytes over a two-wire open-drain bus whose clock line is driven from outside. Both lines are synchronised to the system clock. On each falling SCL edge the block presents the next transmit bit, most significant first. On each rising SCL edge it samples SDA into a receive shifter. A frame is eight data bits followed by a ninth acknowledge bit. During the ninth bit the block can drive a programmed acknowledge value, and it samples whatever level the bus carries at the ninth rising edge. That sample becomes an ACK or NACK event pulse, and optionally a DMA request.

Software loads a transmit buffer and reads a receive buffer, each with a status flag. The configuration inputs select how the ninth bit is handled. A start condition (SDA falling while SCL is high) can optionally restart the frame: the transmit shifter is reloaded from the buffer, reception restarts from bit zero, and SCL is stretched low after the ninth clock of the new frame. This restart path only operates when the external clock source is selected.

The outputs are pull-down enables for SDA and SCL. A 1 on an enable means the line is pulled low; a 0 releases it.

Top module: `i2c_byte_engine`

## Requirements
- R1: Transmit data bits leave MSB first. Each bit is presented after an SCL falling edge and held through the following rising edge. A data bit of 0 gives sda_oe_o=1, and a bit of 1 gives sda_oe_o=0.
- R2: Eight SDA samples, taken at SCL rising edges and MSB first, form a byte. At the 8th rising edge of the frame that byte appears on rx_data_o and rx_full_o becomes 1. A pulse on rx_rd_i clears rx_full_o.
- R3: During the 9th bit, SDA is driven with ack_val_i only when gen_cond_en_i=0 and ack_out_en_i=1. In every other case SDA is released.
- R4: If SDA is low at the 9th rising edge, ack_evt_o pulses for one cycle.
- R5: If SDA is high at the 9th rising edge and nack_quiet_i=0, nack_evt_o pulses for one cycle. With nack_quiet_i=1 no NACK pulse occurs. ack_evt_o and nack_evt_o are never high together.
- R6: dma_req_o pulses together with ack_evt_o when dma_ack_en_i=1. It stays low in every other case.
- R7: The transmit buffer is taken into the shifter at the falling edge that follows the 9th rising edge, and at the first falling edge after reset. That load sets tx_empty_o=1. Writing the buffer with tx_wr_i clears tx_empty_o. After reset tx_empty_o=1.
- R8: A start condition while restart_init_en_i=1 and ext_clk_sel_i=1 does the following:
  - it reloads the transmit shifter from the buffer and clears the receive bit count;
  - the next frame then starts with the buffer's MSB at the next falling edge;
  - sda_oe_o keeps its level until that edge;
  - tx_empty_o does not change.
- R9: Such a restart enables the clock wait. At the falling edge after the 9th rising edge of the new frame, scl_oe_o becomes 1. It stays 1 until a wait_rel_i pulse.
- R10: With ext_clk_sel_i=0 a start condition is ignored. The bit count continues, and no clock wait follows.
- R11: After reset, sda_oe_o=0, scl_oe_o=0, rx_full_o=0, tx_empty_o=1, and all event outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| tx_wr_i | input | 1 | Write tx_data_i into the transmit buffer |
| tx_data_i | input | DATA_W | Transmit buffer write data |
| rx_rd_i | input | 1 | Receive buffer read strobe, clears rx_full_o |
| ack_out_en_i | input | 1 | Drive the acknowledge bit |
| ack_val_i | input | 1 | Acknowledge value to drive |
| gen_cond_en_i | input | 1 | Condition generation mode; blocks acknowledge driving |
| nack_quiet_i | input | 1 | Suppress NACK events |
| dma_ack_en_i | input | 1 | Issue a DMA request on ACK |
| restart_init_en_i | input | 1 | Restart the frame on a start condition |
| ext_clk_sel_i | input | 1 | External clock source selected |
| wait_rel_i | input | 1 | Release the SCL wait |
| rx_data_o | output | DATA_W | Receive buffer |
| rx_full_o | output | 1 | Receive buffer holds an unread byte |
| tx_empty_o | output | 1 | Transmit buffer was consumed |
| sda_oe_o | output | 1 | Pull SDA low |
| scl_oe_o | output | 1 | Pull SCL low (clock wait) |
| ack_evt_o | output | 1 | ACK detected pulse |
| nack_evt_o | output | 1 | NACK detected pulse |
| dma_req_o | output | 1 | DMA request pulse |

## Verification
The assertions assume three things about the inputs:
- each SCL level lasts several system clocks, so a rising and a falling edge never land in consecutive cycles;
- SDA changes only while SCL is stable;
- the configuration inputs do not move inside a frame.

The bench stays within these limits. It holds every SCL phase for six system clocks and changes its SDA drive only in the low phase, except for deliberate start conditions, which it makes with SCL held high. It changes configuration only between frames. The bus is modelled as a wired AND of the bench drive and the design's pull-down enables, so both transmitted and received bits are observed on the same line.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
  typedef enum logic [2:0] {
    FA_NONE,
    FA_LOAD,
    FA_PRELOAD,
    FA_DATA,
    FA_ACK
  } fall_act_e;
endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prv_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
        prev_q  <= chain_q[STAGES-1];
      end
    end
    assign lvl_o[g] = chain_q[STAGES-1];
    assign prv_o[g] = prev_q;
  end
endmodule

// File: rtl/byte_shift.sv
module byte_shift
  import i2c_eng_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              reinit_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_rd_i,
  input  logic              ack_drive_i,
  input  logic              ack_val_i,
  output logic              sda_out_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              tx_empty_o,
  output logic              ninth_rise_o,
  output logic              ninth_fall_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] tx_sh, tx_buf, rx_sh;
  logic              first_done, preload, ack_seen;
  fall_act_e         fall_act;

  always_comb begin
    fall_act = FA_NONE;
    if (scl_fall_i) begin
      if (bit_cnt == '0) begin
        if (!first_done) fall_act = preload ? FA_PRELOAD : FA_LOAD;
      end else if (bit_cnt == LAST) begin
        fall_act = FA_ACK;
      end else begin
        fall_act = FA_DATA;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt    <= '0;
      tx_sh      <= '1;
      rx_sh      <= '0;
      sda_out_o  <= 1'b1;
      first_done <= 1'b0;
      preload    <= 1'b0;
      ack_seen   <= 1'b0;
    end else if (reinit_i) begin
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= tx_buf;
      preload    <= 1'b1;
      first_done <= 1'b0;
      ack_seen   <= 1'b0;
    end else begin
      if (scl_rise_i) begin
        bit_cnt    <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
        ack_seen   <= (bit_cnt == LAST);
        first_done <= 1'b0;
        if (bit_cnt != LAST) rx_sh <= {rx_sh[DATA_W-2:0], sda_i};
      end
      if (scl_fall_i) ack_seen <= 1'b0;
      case (fall_act)
        FA_LOAD: begin
          sda_out_o  <= tx_buf[DATA_W-1];
          tx_sh      <= {tx_buf[DATA_W-2:0], 1'b1};
          first_done <= 1'b1;
        end
        FA_PRELOAD: begin
          sda_out_o  <= tx_sh[DATA_W-1];
          tx_sh      <= {tx_sh[DATA_W-2:0], 1'b1};
          preload    <= 1'b0;
          first_done <= 1'b1;
        end
        FA_DATA: begin
          sda_out_o <= tx_sh[DATA_W-1];
          tx_sh     <= {tx_sh[DATA_W-2:0], 1'b1};
        end
        FA_ACK:  sda_out_o <= ack_drive_i ? ack_val_i : 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_buf     <= '1;
      tx_empty_o <= 1'b1;
    end else begin
      if (tx_wr_i) tx_buf <= tx_data_i;
      if (tx_wr_i) tx_empty_o <= 1'b0;
      else if (fall_act == FA_LOAD) tx_empty_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o <= '0;
      rx_full_o <= 1'b0;
    end else if (scl_rise_i && !reinit_i && bit_cnt == PRE_LAST) begin
      rx_data_o <= {rx_sh[DATA_W-2:0], sda_i};
      rx_full_o <= 1'b1;
    end else if (rx_rd_i) begin
      rx_full_o <= 1'b0;
    end
  end

  assign ninth_rise_o = scl_rise_i && !reinit_i && bit_cnt == LAST;
  assign ninth_fall_o = scl_fall_i && !reinit_i && ack_seen;

  AST_RXFULL_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_o) |-> $past(scl_rise_i)); // R2
  AST_REINIT_SDA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_i |=> $stable(sda_out_o)); // R8
  AST_REINIT_TXE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reinit_i && !tx_wr_i) |=> $stable(tx_empty_o)); // R8
  AST_SDA_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_out_o) |-> $past(scl_fall_i)); // R1
endmodule

// File: rtl/ack_events.sv
module ack_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ninth_rise_i,
  input  logic sda_i,
  input  logic nack_quiet_i,
  input  logic dma_ack_en_i,
  output logic ack_evt_o,
  output logic nack_evt_o,
  output logic dma_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_evt_o  <= 1'b0;
      nack_evt_o <= 1'b0;
      dma_req_o  <= 1'b0;
    end else begin
      ack_evt_o  <= ninth_rise_i && !sda_i;
      nack_evt_o <= ninth_rise_i && sda_i && !nack_quiet_i;
      dma_req_o  <= ninth_rise_i && !sda_i && dma_ack_en_i;
    end
  end

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_evt_o |=> !ack_evt_o); // R4
  AST_ACK_NACK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_evt_o && nack_evt_o)); // R5
  AST_DMA_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> ack_evt_o); // R6
endmodule

// File: rtl/scl_wait.sv
module scl_wait (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic ninth_fall_i,
  input  logic release_i,
  output logic hold_o
);
  logic wait_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_en <= 1'b0;
      hold_o  <= 1'b0;
    end else if (release_i) begin
      wait_en <= 1'b0;
      hold_o  <= 1'b0;
    end else begin
      if (arm_i) wait_en <= 1'b1;
      if (ninth_fall_i && wait_en) hold_o <= 1'b1;
    end
  end

  AST_HOLD_AFTER_NINTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(ninth_fall_i)); // R9
  AST_HOLD_UNTIL_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o) |-> $past(release_i)); // R9
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_rd_i,
  input  logic              ack_out_en_i,
  input  logic              ack_val_i,
  input  logic              gen_cond_en_i,
  input  logic              nack_quiet_i,
  input  logic              dma_ack_en_i,
  input  logic              restart_init_en_i,
  input  logic              ext_clk_sel_i,
  input  logic              wait_rel_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              tx_empty_o,
  output logic              sda_oe_o,
  output logic              scl_oe_o,
  output logic              ack_evt_o,
  output logic              nack_evt_o,
  output logic              dma_req_o
);
  localparam int SCL_IDX = 0;
  localparam int SDA_IDX = 1;

  logic [1:0] lvl, prv;
  logic scl_rise, scl_fall, start_det, reinit, sda_out, ninth_rise, ninth_fall;

  bus_line_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .raw_i ({sda_i, scl_i}),
    .lvl_o (lvl),
    .prv_o (prv)
  );

  assign scl_rise  = lvl[SCL_IDX] & ~prv[SCL_IDX];
  assign scl_fall  = ~lvl[SCL_IDX] & prv[SCL_IDX];
  // start: SDA falls while SCL stays high
  assign start_det = ~lvl[SDA_IDX] & prv[SDA_IDX] & lvl[SCL_IDX] & prv[SCL_IDX];
  assign reinit    = start_det & restart_init_en_i & ext_clk_sel_i;

  byte_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .scl_rise_i   (scl_rise),
    .scl_fall_i   (scl_fall),
    .sda_i        (lvl[SDA_IDX]),
    .reinit_i     (reinit),
    .tx_wr_i,
    .tx_data_i,
    .rx_rd_i,
    .ack_drive_i  (ack_out_en_i & ~gen_cond_en_i),
    .ack_val_i,
    .sda_out_o    (sda_out),
    .rx_data_o,
    .rx_full_o,
    .tx_empty_o,
    .ninth_rise_o (ninth_rise),
    .ninth_fall_o (ninth_fall)
  );

  ack_events u_evt (
    .clk_i, .rst_ni,
    .ninth_rise_i (ninth_rise),
    .sda_i        (lvl[SDA_IDX]),
    .nack_quiet_i,
    .dma_ack_en_i,
    .ack_evt_o,
    .nack_evt_o,
    .dma_req_o
  );

  scl_wait u_wait (
    .clk_i, .rst_ni,
    .arm_i        (reinit),
    .ninth_fall_i (ninth_fall),
    .release_i    (wait_rel_i),
    .hold_o       (scl_oe_o)
  );

  assign sda_oe_o = ~sda_out;

  AST_NO_WAIT_INT_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det && !ext_clk_sel_i && !scl_oe_o) |=> !scl_oe_o); // R10
endmodule

// File: tb/tb_i2c_byte_engine.sv
`timescale 1ns/1ps
module tb_i2c_byte_engine;
  localparam int H = 6;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic m_scl = 1, m_sda = 1;
  logic tx_wr = 0, rx_rd = 0, wait_rel = 0;
  logic [7:0] tx_data = 0;
  logic ack_out_en = 0, ack_val = 0, gen_cond = 0, nack_quiet = 0, dma_en = 0;
  logic reinit_en = 0, ext_clk = 1;
  logic [7:0] rx_data;
  logic rx_full, tx_empty, sda_oe, scl_oe, ack_evt, nack_evt, dma_req;
  wire sda_line = m_sda & ~sda_oe;
  wire scl_line = m_scl & ~scl_oe;

  i2c_byte_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .rx_rd_i(rx_rd),
    .ack_out_en_i(ack_out_en), .ack_val_i(ack_val), .gen_cond_en_i(gen_cond),
    .nack_quiet_i(nack_quiet), .dma_ack_en_i(dma_en),
    .restart_init_en_i(reinit_en), .ext_clk_sel_i(ext_clk), .wait_rel_i(wait_rel),
    .rx_data_o(rx_data), .rx_full_o(rx_full), .tx_empty_o(tx_empty),
    .sda_oe_o(sda_oe), .scl_oe_o(scl_oe), .ack_evt_o(ack_evt),
    .nack_evt_o(nack_evt), .dma_req_o(dma_req)
  );

  int checks = 0, errors = 0;
  int n_ack = 0, n_nack = 0, n_dma = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (ack_evt) n_ack++;
    if (nack_evt) n_nack++;
    if (dma_req) n_dma++;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    tx_data = d; tx_wr = 1; wt(1); tx_wr = 0;
  endtask

  task automatic pulse_rd();
    rx_rd = 1; wt(1); rx_rd = 0;
  endtask

  // one bit: drive in low phase, rise, sample bus, fall
  task automatic clk_bit(input logic b, output logic seen);
    m_sda = b; wt(H);
    m_scl = 1; wt(H);
    seen = sda_line; wt(H);
    m_scl = 0; wt(H);
  endtask

  task automatic do_start();
    m_sda = 1; wt(H);
    m_scl = 1; wt(H);
    m_sda = 0; wt(H);
    m_scl = 0; wt(H);
  endtask

  task automatic run_frame(input logic [7:0] m, input logic mack, input logic [7:0] nxt,
                           output logic [7:0] seen, output logic seen_ack);
    logic s;
    for (int i = 0; i < 8; i++) begin
      clk_bit(m[7-i], s);
      seen[7-i] = s;
    end
    pulse_wr(nxt);
    clk_bit(mack, seen_ack);
    m_sda = 1;
  endtask

  // {tx, master byte, master ack, ack_out_en, ack_val, gen_cond, nack_quiet, dma_en}
  localparam logic [21:0] VEC [6] = '{
    {8'hA5, 8'hFF, 6'b100000},
    {8'hFF, 8'h3C, 6'b000001},
    {8'hFF, 8'hC3, 6'b110000},
    {8'h0F, 8'hF0, 6'b111010},
    {8'h81, 8'hFF, 6'b110100},
    {8'h00, 8'hFF, 6'b000001}
  };

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] seen, tx, m;
    logic sack, exp_ack, s;
    int a0, n0, d0;
    wt(3); rst_n = 1; wt(4);
    check("R11 sda_oe", sda_oe, 0);
    check("R11 scl_oe", scl_oe, 0);
    check("R11 rx_full", rx_full, 0);
    check("R11 tx_empty", tx_empty, 1);
    check("R11 events", {ack_evt, nack_evt, dma_req}, 0);

    pulse_wr(VEC[0][21:14]);
    check("R7 tx_empty after write", tx_empty, 0);
    do_start();
    check("R7 tx_empty after load", tx_empty, 1);

    for (int k = 0; k < 6; k++) begin
      tx = VEC[k][21:14]; m = VEC[k][13:6];
      {ack_out_en, ack_val, gen_cond, nack_quiet, dma_en} = VEC[k][4:0];
      a0 = n_ack; n0 = n_nack; d0 = n_dma;
      run_frame(m, VEC[k][5], (k < 5) ? VEC[k+1][21:14] : 8'hFF, seen, sack);
      exp_ack = VEC[k][5] & ((ack_out_en & ~gen_cond) ? ack_val : 1'b1);
      check($sformatf("R1 tx bits v%0d", k), seen, tx & m);
      check($sformatf("R2 rx byte v%0d", k), rx_data, tx & m);
      check($sformatf("R2 rx_full v%0d", k), rx_full, 1);
      pulse_rd();
      check($sformatf("R2 rx_full cleared v%0d", k), rx_full, 0);
      check($sformatf("R3 ack line v%0d", k), sack, exp_ack);
      check($sformatf("R4 ack events v%0d", k), n_ack - a0, !exp_ack);
      check($sformatf("R5 nack events v%0d", k), n_nack - n0, exp_ack & ~nack_quiet);
      check($sformatf("R6 dma events v%0d", k), n_dma - d0, !exp_ack & dma_en);
      check($sformatf("R7 tx_empty v%0d", k), tx_empty, 1);
    end
    {ack_out_en, ack_val, gen_cond, nack_quiet, dma_en} = 5'b0;

    // R8/R9: restart three bits into a 0xFF frame
    for (int i = 0; i < 3; i++) clk_bit(1'b1, s);
    reinit_en = 1; ext_clk = 1;
    pulse_wr(8'h5A);
    m_sda = 1; wt(H);
    m_scl = 1; wt(H);
    m_sda = 0; wt(H);
    check("R8 sda held at start", sda_oe, 0);
    check("R8 tx_empty kept", tx_empty, 0);
    m_scl = 0; wt(H);
    check("R8 first new bit", sda_oe, 1);
    check("R8 tx_empty after first fall", tx_empty, 0);
    reinit_en = 0;
    run_frame(8'hFF, 1'b1, 8'h5A, seen, sack);
    check("R8 restarted bits", seen, 8'h5A);
    check("R8 restarted rx", rx_data, 8'h5A);
    pulse_rd();
    check("R9 scl held", scl_oe, 1);
    wt(20);
    check("R9 scl still held", scl_oe, 1);
    wait_rel = 1; wt(1); wait_rel = 0; wt(2);
    check("R9 scl released", scl_oe, 0);

    // R10: start with internal clock selected is ignored
    reinit_en = 1; ext_clk = 0;
    for (int i = 0; i < 3; i++) clk_bit(1'b1, s);
    do_start();
    for (int i = 0; i < 4; i++) clk_bit(1'b1, s);
    check("R10 rx_full count continued", rx_full, 1);
    check("R10 rx byte", rx_data, 8'h5A);
    pulse_rd();
    clk_bit(1'b1, s);
    wt(4);
    check("R10 no wait", scl_oe, 0);
    reinit_en = 0; ext_clk = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule